// File: doc/BRIEF.md
# Interleaved Four-Lane Word Serializer

The serializer sits at the front of a fast converter datapath. It takes four 12-bit lanes, labelled A to D, and hands one word per fast-clock cycle to the datapath behind it. A counter running on the fast clock is the only timing source. Its low bit toggles every cycle and its high bit every second cycle, and these two bits pick the lane. The same counter produces a slower companion clock. Upstream logic uses that clock to pace the data it drives onto the lanes.

A static strap, `pair_mode`, picks the interleave. When it is low, all four lanes are sent in the order A, B, C, D and a frame lasts four fast cycles. When it is high, only the two middle lanes are sent, in the order B, C, and a frame lasts two cycles. All four lanes are loaded into a holding register on the fast edge that ends a frame. That edge is the same edge on which the slow clock rises. The lane selected in each slot is registered once more before it reaches `word_out`.

The timing from capture to output is fixed. The word for slot k appears k+1 fast cycles after the capture edge.

Top module: `quad_lane_serializer`

## Requirements
- R1: After a clock edge that samples `rst_n` low, `word_out` is 0, the frame phase is 0 and `slow_clk` is 1. The first frame after reset releases outputs 0 in every slot.
- R2: With `pair_mode` = 0, the words captured at one capture edge come out in four successive cycles in the order lane A, lane B, lane C, lane D.
- R3: With `pair_mode` = 1, the captured words come out in two successive cycles in the order lane B, lane C. Lanes A and D never reach `word_out`.
- R4: With `pair_mode` = 0, `slow_clk` has a period of four fast cycles. It is high for the first two cycles of a frame and low for the last two.
- R5: With `pair_mode` = 1, `slow_clk` has a period of two fast cycles. It is high for the first cycle of a frame and low for the second.
- R6: Lanes are sampled only at the capture edge, which is the fast edge on which `slow_clk` rises. Lane values that are present only at other edges have no effect on `word_out`.
- R7: The word for slot k (k = 0 for the first slot) appears on `word_out` k+1 fast cycles after its capture edge. Reset releases at phase 0, so the first capture edge is the 4th edge (or the 2nd edge in two-lane mode) after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; one output word per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_mode | input | 1 | 0: four-lane interleave A,B,C,D; 1: two-lane interleave B,C (static) |
| lane_a | input | 12 | Lane A word, bit 11 is the MSB |
| lane_b | input | 12 | Lane B word |
| lane_c | input | 12 | Lane C word |
| lane_d | input | 12 | Lane D word |
| slow_clk | output | 1 | Companion clock for the upstream source; rises at each capture edge |
| word_out | output | 12 | Serialized, registered output word |

## Verification
If the divider phase were wrong, the output would show it within one frame. `slow_clk` would lose its period or its duty cycle, and the slot words would come out rotated or repeated. A capture register loaded on the wrong edge would let mid-frame lane values leak into the output. That shows up in the frame right after the stray load. A stale output register or a wrong lane index puts a wrong word on `word_out` one cycle after the slot it belongs to. So every kind of internal fault reaches the ports within one frame plus one cycle.

// File: rtl/qls_pkg.sv
// Shared constants and types for the lane serializer.
// Assumes a power-of-two lane count of at least four.
package qls_pkg;
    localparam int NUM_LANES = 4;
    localparam int IDX_W     = $clog2(NUM_LANES);

    typedef logic [IDX_W-1:0] lane_idx_t;

    // Lane index of the first lane used in two-lane mode (lane B)
    localparam lane_idx_t PAIR_BASE  = lane_idx_t'(1);
    localparam lane_idx_t FULL_LAST  = lane_idx_t'(NUM_LANES - 1);
    localparam lane_idx_t PAIR_LAST  = lane_idx_t'(1);
    localparam lane_idx_t FULL_HALF  = lane_idx_t'(NUM_LANES / 2);
    localparam lane_idx_t PAIR_HALF  = lane_idx_t'(1);
endpackage

// File: rtl/qls_phase_gen.sv
// Frame phase divider. Counts fast cycles within a frame. The counter bits
// are the lane selects. It also produces the capture strobe, the lane index
// and the registered slow companion clock.
// Assumes pair_mode is static, or changes only while reset is held.
module qls_phase_gen
    import qls_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pair_mode,
    output lane_idx_t phase,
    output lane_idx_t lane_idx,
    output logic      capture,
    output logic      slow_clk
);
    lane_idx_t frame_last;
    lane_idx_t half_len;
    lane_idx_t phase_nxt;
    logic      slow_q;

    // Frame length and high time of the slow clock for the selected mode
    always_comb begin
        frame_last = pair_mode ? PAIR_LAST : FULL_LAST;
        half_len   = pair_mode ? PAIR_HALF : FULL_HALF;
    end

    // Next phase wraps at the last slot; the strobe marks the frame-ending edge
    always_comb begin
        capture   = (phase >= frame_last);
        phase_nxt = capture ? '0 : phase + lane_idx_t'(1);
    end

    // Phase counter, cleared by reset to the first slot
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase_nxt;
    end

    // Slow clock: high in the first half of each frame, registered so it is glitch free
    always_ff @(posedge clk) begin
        if (!rst_n) slow_q <= 1'b1;
        else        slow_q <= (phase_nxt < half_len);
    end

    // Two-lane mode offsets the slot number onto the middle lanes
    always_comb lane_idx = pair_mode ? (phase + PAIR_BASE) : phase;

    assign slow_clk = slow_q;
endmodule

// File: rtl/qls_lane_capture.sv
// Input holding registers, one per lane. All lanes load together on the
// capture strobe and hold their value for the whole frame.
// Assumes the lanes are stable around the capture edge.
module qls_lane_capture
    import qls_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [NUM_LANES-1:0][WORD_W-1:0] lanes_in,
    output logic [NUM_LANES-1:0][WORD_W-1:0] lanes_q
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Hold register for one lane, loaded at the end of each frame
        always_ff @(posedge clk) begin
            if (!rst_n)    lanes_q[g] <= '0;
            else if (load) lanes_q[g] <= lanes_in[g];
        end
    end
endmodule

// File: rtl/qls_slot_select.sv
// Lane multiplexer followed by the output register. Each cycle it picks
// one held lane by index and registers it onto the output.
// Assumes the lane index is always below the lane count.
module qls_slot_select
    import qls_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  lane_idx_t                        lane_idx,
    input  logic [NUM_LANES-1:0][WORD_W-1:0] lanes_q,
    output logic [WORD_W-1:0]                word_out
);
    logic [WORD_W-1:0] picked;

    // Select the held word for the current slot
    always_comb picked = lanes_q[lane_idx];

    // Re-register the chosen word before it leaves the block
    always_ff @(posedge clk) begin
        if (!rst_n) word_out <= '0;
        else        word_out <= picked;
    end
endmodule

// File: rtl/quad_lane_serializer.sv
// Top of the lane serializer. It packs the four lane ports, then connects
// the phase divider, the capture registers and the slot selector.
// Assumes pair_mode is a strap, held static outside of reset.
module quad_lane_serializer
    import qls_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              pair_mode,
    input  logic [WORD_W-1:0] lane_a,
    input  logic [WORD_W-1:0] lane_b,
    input  logic [WORD_W-1:0] lane_c,
    input  logic [WORD_W-1:0] lane_d,
    output logic              slow_clk,
    output logic [WORD_W-1:0] word_out
);
    logic [NUM_LANES-1:0][WORD_W-1:0] lanes_in;
    logic [NUM_LANES-1:0][WORD_W-1:0] lanes_q;
    lane_idx_t phase;
    lane_idx_t lane_idx;
    logic      capture;

    // Pack lane ports so that index 0 is lane A
    always_comb begin
        lanes_in[0] = lane_a;
        lanes_in[1] = lane_b;
        lanes_in[2] = lane_c;
        lanes_in[3] = lane_d;
    end

    qls_phase_gen u_phase (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .pair_mode (pair_mode),
        .phase     (phase),
        .lane_idx  (lane_idx),
        .capture   (capture),
        .slow_clk  (slow_clk)
    );

    qls_lane_capture #(.WORD_W(WORD_W)) u_capture (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .load     (capture),
        .lanes_in (lanes_in),
        .lanes_q  (lanes_q)
    );

    qls_slot_select #(.WORD_W(WORD_W)) u_select (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .lane_idx (lane_idx),
        .lanes_q  (lanes_q),
        .word_out (word_out)
    );
endmodule

// File: rtl/qls_checker.sv
// Property checker for the lane serializer, bound to the top module.
// It compares the divider phase against the lane ports and the outputs.
module qls_checker
    import qls_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_mode,
    input logic [WORD_W-1:0] lane_a,
    input logic [WORD_W-1:0] lane_b,
    input logic [WORD_W-1:0] lane_d,
    input logic              slow_clk,
    input logic [WORD_W-1:0] word_out,
    input lane_idx_t         phase
);
    // R4
    full_slow_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && $rose(slow_clk)) |->
            (!$past(slow_clk) && !$past(slow_clk, 2) && $past(slow_clk, 3)));

    // R5
    pair_slow_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && $rose(slow_clk)) |-> (!$past(slow_clk) && $past(slow_clk, 2)));

    // R2
    full_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && phase == FULL_LAST) |=> ##1 (word_out == $past(lane_a, 2)));

    // R3
    pair_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && phase == PAIR_LAST) |=> ##1 (word_out == $past(lane_b, 2)));

    // R7
    full_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && phase == FULL_LAST) |=> ##4 (word_out == $past(lane_d, 5)));
endmodule

bind quad_lane_serializer qls_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk_fast),
    .rst_n     (rst_n),
    .pair_mode (pair_mode),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .lane_d    (lane_d),
    .slow_clk  (slow_clk),
    .word_out  (word_out),
    .phase     (phase)
);

// File: tb/tb_quad_lane_serializer.sv
// Directed bench for the lane serializer. Each task is one scenario and
// checks its own results at the falling edge.
module tb_quad_lane_serializer;
    localparam int W = 12;

    logic         clk_fast = 1'b0;
    logic         rst_n    = 1'b0;
    logic         pair_mode = 1'b0;
    logic [W-1:0] lane_a = '0, lane_b = '0, lane_c = '0, lane_d = '0;
    logic         slow_clk;
    logic [W-1:0] word_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    quad_lane_serializer #(.WORD_W(W)) dut (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .pair_mode(pair_mode),
        .lane_a   (lane_a),
        .lane_b   (lane_b),
        .lane_c   (lane_c),
        .lane_d   (lane_d),
        .slow_clk (slow_clk),
        .word_out (word_out)
    );

    always #10 clk_fast = ~clk_fast;

    // Word driven on lane l during frame i of a scenario
    function automatic logic [W-1:0] pat(int i, int l, int seed);
        if (i == 1) return 12'hFFF ^ W'(l);
        if (i == 2) return W'(1) << (l * 3);
        return W'(seed * 3 + i * 409 + l * 1171 + 5);
    endfunction

    function automatic logic [W-1:0] junk(int m, int l);
        return W'(12'hA5A ^ (m * 77) ^ (l * 301));
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_lanes(int i, int seed);
        lane_a = pat(i, 0, seed); lane_b = pat(i, 1, seed);
        lane_c = pat(i, 2, seed); lane_d = pat(i, 3, seed);
    endtask

    // R1: hold reset for three edges, then check the reset state and release
    task automatic do_reset(bit mode, int seed);
        @(negedge clk_fast);
        rst_n = 1'b0;
        pair_mode = mode;
        set_lanes(0, seed);
        repeat (3) @(negedge clk_fast);
        check("R1 word_out", word_out, '0);
        check("R1 slow_clk", W'(slow_clk), W'(1));
        rst_n = 1'b1;
    endtask

    // R2..R7: run a number of frames from reset release, checking every cycle
    task automatic run_frames(bit mode, int frames, int seed, bit with_junk);
        int f = mode ? 2 : 4;
        for (int m = 1; m <= frames * f; m++) begin
            @(negedge clk_fast);
            begin
                int ph = m % f;
                int k  = (m - 1) % f;
                int n  = m - 1 - k;
                int ln = mode ? k + 1 : k;
                logic [W-1:0] exp;
                string tag;
                check(mode ? "R5 slow_clk" : "R4 slow_clk", W'(slow_clk), W'(ph < f / 2));
                exp = (n == 0) ? '0 : pat(n / f - 1, ln, seed);
                if (k == 0)          tag = "R7 word_out";
                else if (with_junk)  tag = "R6 word_out";
                else if (mode)       tag = "R3 word_out";
                else                 tag = "R2 word_out";
                check(tag, word_out, exp);
                if (ph == 0 || ph == f - 1 || !with_junk) set_lanes(m / f, seed);
                else begin
                    lane_a = junk(m, 0); lane_b = junk(m, 1);
                    lane_c = junk(m, 2); lane_d = junk(m, 3);
                end
            end
        end
    endtask

    task automatic test_four_lane();
        do_reset(1'b0, 11);
        run_frames(1'b0, 7, 11, 1'b0);
    endtask

    task automatic test_four_lane_midframe_changes();
        do_reset(1'b0, 29);
        run_frames(1'b0, 6, 29, 1'b1);
    endtask

    task automatic test_two_lane();
        do_reset(1'b1, 43);
        run_frames(1'b1, 8, 43, 1'b0);
    endtask

    task automatic test_reset_mid_frame();
        do_reset(1'b0, 57);
        run_frames(1'b0, 2, 57, 1'b0);
        repeat (2) @(negedge clk_fast);
        do_reset(1'b0, 71);
        run_frames(1'b0, 4, 71, 1'b0);
    endtask

    initial begin
        test_four_lane();
        test_four_lane_midframe_changes();
        test_two_lane();
        test_reset_mid_frame();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk_fast);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule